// File: doc/BRIEF.md
# Row Pooling and Shift Stage

This stage post-processes output feature maps one complete row per beat. Each beat carries a row of 4-bit activations and that row's index within the layer. The stage can reduce the map with 2x2, stride-2 max pooling. For this it keeps the most recent even row in a one-row holding register and combines it with the following odd row in a single cycle. It then applies the layer's spatial shift and presents the finished row together with the destination row index at which a downstream writer should store it.

A horizontal shift (left or right) moves the pixels inside the row vector by one position. A vertical shift (up or down) never touches the data: only the destination row index moves by one. The row that would fall off the top or bottom edge is not written. Its beat carries an all-zero row addressed to the opposite edge, so the map that is written is complete and every productive beat still yields exactly one output. The configuration (width, row count, pool enable, shift code) is held steady for the duration of a layer.

Top module: `row_pool_shift`

## Requirements
- R1: After reset, `valid_o` is 0, `row_o` is all zeros and `dst_row_o` is 0.
- R2: With pooling off and shift code 0 (none), each input beat produces one output beat on the next cycle, carrying the same in-width pixels and `dst_row_o` equal to `row_idx_i`. Back-to-back beats produce back-to-back outputs with no gaps.
- R3: Pixel c occupies bits [4c+3:4c] of a row. Input pixels at positions at or beyond `cfg_width_i` have no effect. Output pixels at or beyond the effective width (`cfg_width_i` without pooling, `cfg_width_i`/2 with pooling) are zero.
- R4: With pooling on, a beat with an even `row_idx_i` produces no output and is held. A beat with an odd index produces, on the next cycle, a row whose pixel j is the maximum of pixels 2j and 2j+1 of the held row and of the current row. Its output row index is `row_idx_i`/2 and its effective width is `cfg_width_i`/2.
- R5: Shift code 3 (left) gives output pixel c = pixel c+1 of the pre-shift row, and the last in-width pixel is zero.
- R6: Shift code 4 (right) gives output pixel c = pixel c-1 of the pre-shift row, and pixel 0 is zero.
- R7: Shift code 1 (up) writes output row r to destination r-1 with unchanged data. The beat for output row 0 instead emits an all-zero row to destination (output row count - 1).
- R8: Shift code 2 (down) writes output row r to destination r+1 with unchanged data. The beat for the last output row instead emits an all-zero row to destination 0.
- R9: Shift codes 5, 6 and 7 behave exactly as code 0.
- R10: With pooling on, the shift applies to the pooled row. The output row count is `cfg_rows_i`/2 and horizontal edges use the halved width.
- R11: A cycle with `row_valid_i` low produces `valid_o` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_width_i | input | W_W | Pixels per input row (runtime, up to MAX_W) |
| cfg_rows_i | input | ROW_W | Input rows in the layer |
| cfg_pool_i | input | 1 | Enable 2x2 stride-2 max pooling |
| cfg_shift_i | input | 3 | Shift code: 0 none, 1 up, 2 down, 3 left, 4 right |
| row_valid_i | input | 1 | Input row beat valid |
| row_idx_i | input | ROW_W | Index of the input row |
| row_data_i | input | MAX_W*PIX_W | Input row, pixel c at bits [PIX_W*c +: PIX_W] |
| valid_o | output | 1 | Output row valid |
| row_o | output | MAX_W*PIX_W | Output row |
| dst_row_o | output | ROW_W | Destination row index for writeback |

## Verification
The in-line assertions check, on every cycle, the beat-level timing: no gap behind a non-pooled beat, silence behind an even pooled row and behind an idle cycle, and identity addressing when no shift is selected. They also check that the held row changes only on even pooled beats, that destinations stay inside the output map, and that the zero fill at the horizontal edges holds. The pixel arithmetic cannot be shown by a per-cycle property. Only the bench's scenarios show it: the 2x2 maximum across two rows, the masking of junk pixels beyond the runtime width, the direction of each horizontal move, and the zero edge row that replaces the suppressed vertical row.

// File: rtl/row_ps_pkg.sv
package row_ps_pkg;

  typedef enum logic [2:0] {
    SH_NONE  = 3'd0,
    SH_UP    = 3'd1,
    SH_DOWN  = 3'd2,
    SH_LEFT  = 3'd3,
    SH_RIGHT = 3'd4
  } shift_e;

  function automatic shift_e decode_shift(input logic [2:0] code);
    case (code)
      3'd1:    return SH_UP;
      3'd2:    return SH_DOWN;
      3'd3:    return SH_LEFT;
      3'd4:    return SH_RIGHT;
      default: return SH_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rps_pool.sv
module rps_pool #(
  parameter int MAX_W = 16,
  parameter int PIX_W = 4,
  parameter int W_W   = $clog2(MAX_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          pool_en_i,
  input  logic                          odd_i,
  input  logic [W_W-1:0]                width_i,
  input  logic [MAX_W-1:0][PIX_W-1:0]   row_i,
  output logic [MAX_W-1:0][PIX_W-1:0]   cur_o,
  output logic [MAX_W-1:0][PIX_W-1:0]   pooled_o
);

  localparam int HALF = MAX_W / 2;

  logic [MAX_W-1:0][PIX_W-1:0] cur_m;
  logic [MAX_W-1:0][PIX_W-1:0] held_q;

  // drop pixels past the runtime width
  for (genvar c = 0; c < MAX_W; c++) begin : g_mask
    localparam logic [W_W-1:0] CI = W_W'(c);
    assign cur_m[c] = (CI < width_i) ? row_i[c] : '0;
  end

  assign cur_o = cur_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             held_q <= '0;
    else if (valid_i && pool_en_i && !odd_i) held_q <= cur_m;
  end

  for (genvar j = 0; j < MAX_W; j++) begin : g_pool
    if (j < HALF) begin : g_act
      logic [PIX_W-1:0] cur_mx, held_mx;
      assign cur_mx  = (cur_m[2*j]  > cur_m[2*j+1])  ? cur_m[2*j]  : cur_m[2*j+1];
      assign held_mx = (held_q[2*j] > held_q[2*j+1]) ? held_q[2*j] : held_q[2*j+1];
      assign pooled_o[j] = (cur_mx > held_mx) ? cur_mx : held_mx;
    end else begin : g_zero
      assign pooled_o[j] = '0;
    end
  end

  // held row may only change on even pooled beats
  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && pool_en_i && !odd_i) |=> $stable(held_q));

endmodule

// File: rtl/rps_hshift.sv
module rps_hshift
  import row_ps_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int PIX_W = 4,
  parameter int W_W   = $clog2(MAX_W + 1)
) (
  input  shift_e                        shift_i,
  input  logic [W_W-1:0]                ew_i,
  input  logic [MAX_W-1:0][PIX_W-1:0]   row_i,
  output logic [MAX_W-1:0][PIX_W-1:0]   row_o
);

  logic [MAX_W-1:0][PIX_W-1:0] in_m;

  for (genvar c = 0; c < MAX_W; c++) begin : g_sh
    localparam logic [W_W-1:0] CI = W_W'(c);
    logic [PIX_W-1:0] from_right, from_left;

    assign in_m[c] = (CI < ew_i) ? row_i[c] : '0;

    if (c + 1 < MAX_W) begin : g_r
      assign from_right = in_m[c+1];
    end else begin : g_rz
      assign from_right = '0;
    end

    if (c > 0) begin : g_l
      assign from_left = in_m[c-1];
    end else begin : g_lz
      assign from_left = '0;
    end

    always_comb begin
      if (CI >= ew_i) row_o[c] = '0;
      else begin
        case (shift_i)
          SH_LEFT:  row_o[c] = from_right;
          SH_RIGHT: row_o[c] = from_left;
          default:  row_o[c] = in_m[c];
        endcase
      end
    end
  end

endmodule

// File: rtl/rps_vaddr.sv
module rps_vaddr
  import row_ps_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic [ROW_W-1:0] idx_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic             pool_i,
  input  shift_e           shift_i,
  output logic [ROW_W-1:0] out_rows_o,
  output logic [ROW_W-1:0] dst_o,
  output logic             zero_o
);

  logic [ROW_W-1:0] out_idx;
  logic [ROW_W-1:0] last_row;

  assign out_idx    = pool_i ? (idx_i >> 1)  : idx_i;
  assign out_rows_o = pool_i ? (rows_i >> 1) : rows_i;
  assign last_row   = out_rows_o - 1'b1;

  // vertical shift moves only the address; the edge beat carries the zero fill
  always_comb begin
    zero_o = 1'b0;
    dst_o  = out_idx;
    case (shift_i)
      SH_UP: begin
        if (out_idx == '0) begin
          zero_o = 1'b1;
          dst_o  = last_row;
        end else begin
          dst_o = out_idx - 1'b1;
        end
      end
      SH_DOWN: begin
        if (out_idx == last_row) begin
          zero_o = 1'b1;
          dst_o  = '0;
        end else begin
          dst_o = out_idx + 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/row_pool_shift.sv
module row_pool_shift
  import row_ps_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int PIX_W = 4,
  parameter int ROW_W = 8,
  parameter int W_W   = $clog2(MAX_W + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [W_W-1:0]           cfg_width_i,
  input  logic [ROW_W-1:0]         cfg_rows_i,
  input  logic                     cfg_pool_i,
  input  logic [2:0]               cfg_shift_i,
  input  logic                     row_valid_i,
  input  logic [ROW_W-1:0]         row_idx_i,
  input  logic [MAX_W*PIX_W-1:0]   row_data_i,
  output logic                     valid_o,
  output logic [MAX_W*PIX_W-1:0]   row_o,
  output logic [ROW_W-1:0]         dst_row_o
);

  shift_e                      shift;
  logic [MAX_W-1:0][PIX_W-1:0] row_in, cur_row, pooled_row, sel_row, shifted_row;
  logic [W_W-1:0]              eff_w;
  logic [ROW_W-1:0]            out_rows, dst_c;
  logic                        zero_c, emit;

  logic                        valid_q;
  logic [MAX_W-1:0][PIX_W-1:0] row_q;
  logic [ROW_W-1:0]            dst_q;

  assign shift  = decode_shift(cfg_shift_i);
  assign row_in = row_data_i;
  assign emit   = row_valid_i && (!cfg_pool_i || row_idx_i[0]);

  rps_pool #(.MAX_W(MAX_W), .PIX_W(PIX_W), .W_W(W_W)) u_pool (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (row_valid_i),
    .pool_en_i (cfg_pool_i),
    .odd_i     (row_idx_i[0]),
    .width_i   (cfg_width_i),
    .row_i     (row_in),
    .cur_o     (cur_row),
    .pooled_o  (pooled_row)
  );

  assign sel_row = cfg_pool_i ? pooled_row : cur_row;
  assign eff_w   = cfg_pool_i ? (cfg_width_i >> 1) : cfg_width_i;

  rps_hshift #(.MAX_W(MAX_W), .PIX_W(PIX_W), .W_W(W_W)) u_hshift (
    .shift_i (shift),
    .ew_i    (eff_w),
    .row_i   (sel_row),
    .row_o   (shifted_row)
  );

  rps_vaddr #(.ROW_W(ROW_W)) u_vaddr (
    .idx_i      (row_idx_i),
    .rows_i     (cfg_rows_i),
    .pool_i     (cfg_pool_i),
    .shift_i    (shift),
    .out_rows_o (out_rows),
    .dst_o      (dst_c),
    .zero_o     (zero_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      dst_q   <= '0;
    end else begin
      valid_q <= emit;
      if (emit) begin
        row_q <= zero_c ? '0 : shifted_row;
        dst_q <= dst_c;
      end
    end
  end

  assign valid_o   = valid_q;
  assign row_o     = row_q;
  assign dst_row_o = dst_q;

  assert_no_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_i && !cfg_pool_i) |=> valid_o);

  assert_ident_dst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_i && !cfg_pool_i && cfg_shift_i == 3'd0) |=> dst_row_o == $past(row_idx_i));

  assert_even_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_i && cfg_pool_i && !row_idx_i[0]) |=> !valid_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_valid_i |=> !valid_o);

  assert_dst_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && out_rows != '0 && row_idx_i < cfg_rows_i) |-> dst_c < out_rows);

  assert_left_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && shift == SH_LEFT && eff_w != '0 && eff_w <= W_W'(MAX_W))
      |-> shifted_row[eff_w - 1'b1] == '0);

  assert_right_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && shift == SH_RIGHT) |-> shifted_row[0] == '0);

endmodule

// File: tb/row_pool_shift_tb.sv
`timescale 1ns/1ps
module row_pool_shift_tb;

  localparam int MAX_W = 16;
  localparam int PIX_W = 4;
  localparam int ROW_W = 8;
  localparam int W_W   = $clog2(MAX_W + 1);
  localparam int RB    = MAX_W * PIX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [W_W-1:0]   cfg_width = '0;
  logic [ROW_W-1:0] cfg_rows = '0;
  logic             cfg_pool = 1'b0;
  logic [2:0]       cfg_shift = '0;
  logic             row_valid = 1'b0;
  logic [ROW_W-1:0] row_idx = '0;
  logic [RB-1:0]    row_data = '0;
  logic             valid_o;
  logic [RB-1:0]    row_o;
  logic [ROW_W-1:0] dst_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  row_pool_shift #(.MAX_W(MAX_W), .PIX_W(PIX_W), .ROW_W(ROW_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_width_i (cfg_width),
    .cfg_rows_i  (cfg_rows),
    .cfg_pool_i  (cfg_pool),
    .cfg_shift_i (cfg_shift),
    .row_valid_i (row_valid),
    .row_idx_i   (row_idx),
    .row_data_i  (row_data),
    .valid_o     (valid_o),
    .row_o       (row_o),
    .dst_row_o   (dst_o)
  );

  function automatic logic [RB-1:0] pat(input int seed);
    logic [RB-1:0] r;
    for (int c = 0; c < MAX_W; c++) r[c*PIX_W +: PIX_W] = PIX_W'((seed + c * 7 + (c * c) % 5) & 15);
    return r;
  endfunction

  // expected row from the requirements
  function automatic logic [RB-1:0] mdl(input logic [RB-1:0] cur, input logic [RB-1:0] prv,
                                        input int w, input bit pool, input int sh);
    logic [PIX_W-1:0] a [MAX_W];
    logic [PIX_W-1:0] p [MAX_W];
    logic [PIX_W-1:0] s [MAX_W];
    logic [RB-1:0] r;
    int ew;
    for (int c = 0; c < MAX_W; c++) begin
      a[c] = (c < w) ? cur[c*PIX_W +: PIX_W] : '0;
      p[c] = (c < w) ? prv[c*PIX_W +: PIX_W] : '0;
      s[c] = '0;
    end
    if (pool) begin
      for (int j = 0; j < MAX_W / 2; j++) begin
        logic [PIX_W-1:0] m;
        m = a[2*j];
        if (a[2*j+1] > m) m = a[2*j+1];
        if (p[2*j]   > m) m = p[2*j];
        if (p[2*j+1] > m) m = p[2*j+1];
        s[j] = m;
      end
      ew = w / 2;
    end else begin
      for (int c = 0; c < MAX_W; c++) s[c] = a[c];
      ew = w;
    end
    if (ew > MAX_W) ew = MAX_W;
    if (sh > 4) sh = 0;
    r = '0;
    for (int c = 0; c < ew; c++) begin
      case (sh)
        3:       r[c*PIX_W +: PIX_W] = (c + 1 < ew) ? s[c+1] : '0;
        4:       r[c*PIX_W +: PIX_W] = (c > 0) ? s[c-1] : '0;
        default: r[c*PIX_W +: PIX_W] = s[c];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [RB-1:0] got, input logic [RB-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg(input int w, input int rows, input bit pool, input int sh);
    @(negedge clk);
    cfg_width = W_W'(w);
    cfg_rows  = ROW_W'(rows);
    cfg_pool  = pool;
    cfg_shift = 3'(sh);
  endtask

  task automatic beat(input logic [RB-1:0] d, input int idx);
    @(negedge clk);
    row_valid = 1'b1;
    row_data  = d;
    row_idx   = ROW_W'(idx);
    @(negedge clk);
    row_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [RB-1:0] er, input int ed);
    chk({tag, " valid"}, RB'(valid_o), RB'(1));
    chk({tag, " row"}, row_o, er);
    chk({tag, " dst"}, RB'(dst_o), RB'(ed));
  endtask

  task automatic t_reset;
    chk("R1 valid", RB'(valid_o), '0);
    chk("R1 row", row_o, '0);
    chk("R1 dst", RB'(dst_o), '0);
  endtask

  task automatic t_pass;
    cfg(16, 8, 0, 0);
    for (int k = 0; k < 3; k++) begin
      logic [RB-1:0] d;
      d = pat(k * 5 + 1);
      beat(d, k + 2);
      expect_out("R2 single", mdl(d, '0, 16, 0, 0), k + 2);
    end
    // back-to-back burst, one output per cycle
    @(negedge clk);
    for (int k = 0; k <= 4; k++) begin
      if (k > 0) expect_out("R2 burst", mdl(pat(40 + k - 1), '0, 16, 0, 0), k - 1);
      if (k < 4) begin
        row_valid = 1'b1;
        row_data  = pat(40 + k);
        row_idx   = ROW_W'(k);
      end else row_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_width;
    logic [RB-1:0] d;
    cfg(5, 8, 0, 0);
    d = {RB{1'b1}};
    d[5*PIX_W-1:0] = 20'h3a5c1;
    beat(d, 1);
    expect_out("R3 width5", mdl(d, '0, 5, 0, 0), 1);
    chk("R3 upper zero", row_o >> (5 * PIX_W), '0);
  endtask

  task automatic t_pool;
    logic [RB-1:0] e0, o1;
    cfg(12, 8, 1, 0);
    e0 = pat(3);
    o1 = pat(11);
    e0[13*PIX_W +: PIX_W] = 4'hf;
    beat(e0, 4);
    chk("R4 even quiet", RB'(valid_o), '0);
    beat(o1, 5);
    expect_out("R4 pooled", mdl(o1, e0, 12, 1, 0), 2);
    chk("R4 pooled upper zero", row_o >> (6 * PIX_W), '0);
  endtask

  task automatic t_left;
    logic [RB-1:0] d;
    cfg(10, 8, 0, 3);
    d = pat(7);
    beat(d, 3);
    expect_out("R5 left", mdl(d, '0, 10, 0, 3), 3);
    chk("R5 pix0", RB'(row_o[0 +: PIX_W]), RB'(d[PIX_W +: PIX_W]));
  endtask

  task automatic t_right;
    logic [RB-1:0] d;
    cfg(16, 8, 0, 4);
    d = pat(9);
    beat(d, 6);
    expect_out("R6 right", mdl(d, '0, 16, 0, 4), 6);
    chk("R6 top pix", RB'(row_o[15*PIX_W +: PIX_W]), RB'(d[14*PIX_W +: PIX_W]));
  endtask

  task automatic t_up;
    cfg(16, 4, 0, 1);
    beat(pat(20), 0);
    expect_out("R7 edge zero", '0, 3);
    for (int r = 1; r < 4; r++) begin
      beat(pat(20 + r), r);
      expect_out("R7 up", mdl(pat(20 + r), '0, 16, 0, 1), r - 1);
    end
  endtask

  task automatic t_down;
    cfg(16, 4, 0, 2);
    for (int r = 0; r < 3; r++) begin
      beat(pat(30 + r), r);
      expect_out("R8 down", mdl(pat(30 + r), '0, 16, 0, 2), r + 1);
    end
    beat(pat(33), 3);
    expect_out("R8 edge zero", '0, 0);
  endtask

  task automatic t_codes;
    for (int code = 5; code < 8; code++) begin
      cfg(9, 8, 0, code);
      beat(pat(code), 4);
      expect_out("R9 unused code", mdl(pat(code), '0, 9, 0, 0), 4);
    end
  endtask

  task automatic t_pool_shift;
    logic [RB-1:0] e, o;
    cfg(8, 4, 1, 4);
    e = pat(50);
    o = pat(51);
    beat(e, 0);
    beat(o, 1);
    expect_out("R10 pool right", mdl(o, e, 8, 1, 4), 0);
    chk("R10 upper zero", row_o >> (4 * PIX_W), '0);
    cfg(8, 4, 1, 2);
    beat(pat(52), 0);
    beat(pat(53), 1);
    expect_out("R10 pool down", mdl(pat(53), pat(52), 8, 1, 0), 1);
    beat(pat(54), 2);
    beat(pat(55), 3);
    expect_out("R10 pool down edge", '0, 0);
  endtask

  task automatic t_idle;
    cfg(16, 8, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 idle", RB'(valid_o), '0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pass();
    t_width();
    t_pool();
    t_left();
    t_right();
    t_up();
    t_down();
    t_codes();
    t_pool_shift();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule